// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between a narrow port A and a wide port B that is made of two halves of the same width, called the 1B half and the 2B half. From A to B it collects two narrow words that arrive one after the other and shows them together as one wide word. The first word passes through two register stages on its way to the 1B half. The second word passes through one register stage on its way to the 2B half. The second 1B stage and the 2B register share a clock enable, so the held first word and the new second word land on the wide port at the same edge.

From B to A, each half has its own storage register with its own clock enable. A registered select picks which stored half drives A. Every control input is sampled on the rising clock edge before it takes effect: the select and both output enables. Pad tri-stating is modelled as separate in, out and drive-enable signals. After reset, no port is driven.

Top module: `nw_bus_exchanger`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `a_drv`, `b1_drv` and `b2_drv` are 0, and `a_out`, `b1_out` and `b2_out` are all zeros.
- R2: The first 1B stage captures `a_in` on a rising edge when `ab_ld1_n` is 0 and holds its value when `ab_ld1_n` is 1.
- R3: The 2B register, whose value is `b2_out`, captures `a_in` on a rising edge when `ab_ld2_n` is 0 and holds its value otherwise.
- R4: The second 1B stage, whose value is `b1_out`, copies the first 1B stage on a rising edge when `ab_ld2_n` is 0. So word W0 sent with `ab_ld1_n`=0, followed on the next edge by word W1 sent with `ab_ld2_n`=0, gives `b1_out`=W0 and `b2_out`=W1 in the same cycle.
- R5: The 1B-side storage captures `b1_in` when `ba_ld1_n` is 0, and the 2B-side storage captures `b2_in` when `ba_ld2_n` is 0. Each holds its value when its enable is 1.
- R6: `a_out` shows the 1B-side storage when the value of `sel_n` sampled at the previous edge is 0, and the 2B-side storage when it is 1. A change on `sel_n` does not change `a_out` before the next rising edge.
- R7: `a_drv` equals the inverse of `oe_a_n` as sampled at the previous rising edge.
- R8: `b1_drv` and `b2_drv` both equal the inverse of `oe_b_n` as sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | NW | Narrow port, value seen at the pad |
| a_out | output | NW | Narrow port, value driven onto the pad |
| a_drv | output | 1 | Narrow port pad drive enable, active high |
| b1_in | input | NW | Wide port 1B half, pad input |
| b1_out | output | NW | Wide port 1B half, pad output |
| b1_drv | output | 1 | 1B half pad drive enable, active high |
| b2_in | input | NW | Wide port 2B half, pad input |
| b2_out | output | NW | Wide port 2B half, pad output |
| b2_drv | output | 1 | 2B half pad drive enable, active high |
| ab_ld1_n | input | 1 | Active-low load of the first 1B pipeline stage |
| ab_ld2_n | input | 1 | Active-low load of the second 1B stage and of the 2B register |
| ba_ld1_n | input | 1 | Active-low load of the 1B-side storage for A |
| ba_ld2_n | input | 1 | Active-low load of the 2B-side storage for A |
| sel_n | input | 1 | Select; 0 picks the 1B-side storage for A, 1 picks the 2B-side storage |
| oe_a_n | input | 1 | Active-low output enable of port A, registered |
| oe_b_n | input | 1 | Active-low output enable of port B, registered |

## Verification
A directed pair transfer sends two distinct words with the documented enable pattern. It shows whether the extra 1B stage and the shared second enable line the two words up on the wide port, or leave them skewed by one cycle. A sweep then drives every combination of the seven control inputs, twice over, with data that changes arithmetically at every step. This exposes any enable that loads when it should hold, any swapped or merged enable, any inverted select, and any control that acts combinationally rather than one edge late. A final step changes only `sel_n` and checks `a_out` before the next edge, which tells a registered select apart from a live one.

// File: rtl/nw_xchg_pkg.sv
package nw_xchg_pkg;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  localparam int unsigned NUM_HALVES = 2;

  function automatic half_sel_e decode_sel(input logic sel_level);
    decode_sel = sel_level ? HALF_HI : HALF_LO;
  endfunction

  function automatic logic drive_from_oe(input logic oe_level_n);
    drive_from_oe = ~oe_level_n;
  endfunction

endpackage

// File: rtl/nw_ld_reg.sv
module nw_ld_reg #(
  parameter int unsigned WIDTH = 12,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic take;
  assign take = ~ld_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (take) begin
      q <= d;
    end
  end

endmodule

// File: rtl/nw_ctrl_sync.sv
module nw_ctrl_sync
  import nw_xchg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_n,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  output half_sel_e sel_q,
  output logic      a_drive,
  output logic      b_drive
);

  logic sel_r;
  logic oea_r;
  logic oeb_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r <= 1'b1;
      oea_r <= 1'b1;
      oeb_r <= 1'b1;
    end else begin
      sel_r <= sel_n;
      oea_r <= oe_a_n;
      oeb_r <= oe_b_n;
    end
  end

  assign sel_q   = decode_sel(sel_r);
  assign a_drive = drive_from_oe(oea_r);
  assign b_drive = drive_from_oe(oeb_r);

  p_oea_registered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_drive == !$past(oe_a_n)));

  p_oeb_registered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (b_drive == !$past(oe_b_n)));

endmodule

// File: rtl/nw_ab_path.sv
module nw_ab_path #(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld1_n,
  input  logic          ld2_n,
  input  logic [NW-1:0] a_in,
  output logic [NW-1:0] lo_out,
  output logic [NW-1:0] hi_out
);

  logic [NW-1:0] lo_stage1;
  logic          pair_commit;

  assign pair_commit = ~ld2_n;

  nw_ld_reg #(.WIDTH(NW)) u_lo_s1 (
    .clk  (clk),
    .rst_n(rst_n),
    .ld_n (ld1_n),
    .d    (a_in),
    .q    (lo_stage1)
  );

  nw_ld_reg #(.WIDTH(NW)) u_lo_s2 (
    .clk  (clk),
    .rst_n(rst_n),
    .ld_n (ld2_n),
    .d    (lo_stage1),
    .q    (lo_out)
  );

  nw_ld_reg #(.WIDTH(NW)) u_hi (
    .clk  (clk),
    .rst_n(rst_n),
    .ld_n (ld2_n),
    .d    (a_in),
    .q    (hi_out)
  );

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld2_n |=> $stable(hi_out));

  p_lo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld2_n |=> $stable(lo_out));

  p_pair_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_commit && $past(!ld1_n) && $past(rst_n))
      |=> (lo_out == $past(a_in, 2) && hi_out == $past(a_in)));

endmodule

// File: rtl/nw_ba_path.sv
module nw_ba_path
  import nw_xchg_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld1_n,
  input  logic          ld2_n,
  input  logic [NW-1:0] b1_in,
  input  logic [NW-1:0] b2_in,
  input  half_sel_e     sel_q,
  output logic [NW-1:0] a_data
);

  logic [NUM_HALVES-1:0][NW-1:0] held;
  logic [NUM_HALVES-1:0][NW-1:0] src;
  logic [NUM_HALVES-1:0]         ld_n_vec;

  assign src      = {b2_in, b1_in};
  assign ld_n_vec = {ld2_n, ld1_n};

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    nw_ld_reg #(.WIDTH(NW)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .ld_n (ld_n_vec[h]),
      .d    (src[h]),
      .q    (held[h])
    );
  end

  always_comb begin
    unique case (sel_q)
      HALF_LO: a_data = held[0];
      HALF_HI: a_data = held[1];
      default: a_data = held[0];
    endcase
  end

  p_store1_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld1_n |=> $stable(held[0]));

  p_store2_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld2_n |=> (held[1] == $past(b2_in)));

endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger
  import nw_xchg_pkg::*;
#(
  parameter int unsigned NW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] a_in,
  output logic [NW-1:0] a_out,
  output logic          a_drv,
  input  logic [NW-1:0] b1_in,
  output logic [NW-1:0] b1_out,
  output logic          b1_drv,
  input  logic [NW-1:0] b2_in,
  output logic [NW-1:0] b2_out,
  output logic          b2_drv,
  input  logic          ab_ld1_n,
  input  logic          ab_ld2_n,
  input  logic          ba_ld1_n,
  input  logic          ba_ld2_n,
  input  logic          sel_n,
  input  logic          oe_a_n,
  input  logic          oe_b_n
);

  half_sel_e sel_q;
  logic      a_drive;
  logic      b_drive;

  nw_ctrl_sync u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .sel_q  (sel_q),
    .a_drive(a_drive),
    .b_drive(b_drive)
  );

  nw_ab_path #(.NW(NW)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .ld1_n (ab_ld1_n),
    .ld2_n (ab_ld2_n),
    .a_in  (a_in),
    .lo_out(b1_out),
    .hi_out(b2_out)
  );

  nw_ba_path #(.NW(NW)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .ld1_n (ba_ld1_n),
    .ld2_n (ba_ld2_n),
    .b1_in (b1_in),
    .b2_in (b2_in),
    .sel_q (sel_q),
    .a_data(a_out)
  );

  assign a_drv  = a_drive;
  assign b1_drv = b_drive;
  assign b2_drv = b_drive;

  p_b_halves_together_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (b1_drv == b2_drv));

  p_sel_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_n) && $past(rst_n) && ba_ld2_n) |=> $stable(a_out) || $past(!sel_n));

endmodule

// File: tb/tb_nw_bus_exchanger.sv
module tb_nw_bus_exchanger;

  localparam int NW = 12;
  localparam logic [NW-1:0] MASK = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [NW-1:0] a_out, b1_out, b2_out;
  logic          a_drv, b1_drv, b2_drv;
  logic          ab_ld1_n = 1'b1, ab_ld2_n = 1'b1, ba_ld1_n = 1'b1, ba_ld2_n = 1'b1;
  logic          sel_n = 1'b1, oe_a_n = 1'b1, oe_b_n = 1'b1;

  int n_checks = 0;
  int n_fail = 0;

  // bench-side expected state
  logic [NW-1:0] m_s1 = '0, m_lo = '0, m_hi = '0, m_h1 = '0, m_h2 = '0;
  logic          m_sel = 1'b1, m_oea = 1'b1, m_oeb = 1'b1;

  always #4 clk = ~clk;

  nw_bus_exchanger #(.NW(NW)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b1_in(b1_in), .b1_out(b1_out), .b1_drv(b1_drv),
    .b2_in(b2_in), .b2_out(b2_out), .b2_drv(b2_drv),
    .ab_ld1_n(ab_ld1_n), .ab_ld2_n(ab_ld2_n),
    .ba_ld1_n(ba_ld1_n), .ba_ld2_n(ba_ld2_n),
    .sel_n(sel_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
  );

  task automatic chk(input logic [NW-1:0] act, input logic [NW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: update the expected state from the inputs seen at the edge.
  task automatic step();
    logic [NW-1:0] s1_old;
    @(posedge clk);
    s1_old = m_s1;
    if (!ab_ld1_n) m_s1 = a_in;
    if (!ab_ld2_n) begin
      m_lo = s1_old;
      m_hi = a_in;
    end
    if (!ba_ld1_n) m_h1 = b1_in;
    if (!ba_ld2_n) m_h2 = b2_in;
    m_sel = sel_n;
    m_oea = oe_a_n;
    m_oeb = oe_b_n;
    @(negedge clk);
  endtask

  task automatic check_all();
    chk(b1_out, m_lo, "R2/R4 b1_out");
    chk(b2_out, m_hi, "R3 b2_out");
    chk(a_out, m_sel ? m_h2 : m_h1, "R5/R6 a_out");
    chk({{(NW-1){1'b0}}, a_drv}, {{(NW-1){1'b0}}, ~m_oea}, "R7 a_drv");
    chk({{(NW-1){1'b0}}, b1_drv}, {{(NW-1){1'b0}}, ~m_oeb}, "R8 b1_drv");
    chk({{(NW-1){1'b0}}, b2_drv}, {{(NW-1){1'b0}}, ~m_oeb}, "R8 b2_drv");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, during reset and just after release
    repeat (3) @(negedge clk);
    chk(a_out, '0, "R1 a_out in reset");
    chk({{(NW-1){1'b0}}, a_drv | b1_drv | b2_drv}, '0, "R1 drive in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(b1_out | b2_out | a_out, '0, "R1 data after reset");
    chk({{(NW-1){1'b0}}, a_drv | b1_drv | b2_drv}, '0, "R1 drive after reset");

    // R4: directed pair W0 then W1
    a_in = 12'hA5C; ab_ld1_n = 1'b0; ab_ld2_n = 1'b1;
    step();
    a_in = 12'h3E1; ab_ld1_n = 1'b1; ab_ld2_n = 1'b0;
    step();
    ab_ld2_n = 1'b1; a_in = 12'h777;
    chk(b1_out, 12'hA5C, "R4 pair b1_out=W0");
    chk(b2_out, 12'h3E1, "R4 pair b2_out=W1");
    step();
    chk(b1_out, 12'hA5C, "R4 pair held b1_out");
    chk(b2_out, 12'h3E1, "R3 pair held b2_out");

    // sweep every control combination twice with changing data
    for (int k = 0; k < 256; k++) begin
      logic [6:0] c;
      c = k[6:0] ^ 7'(k >> 7);
      a_in  = NW'((k * 37 + 5) & MASK);
      b1_in = NW'((k * 91 + 11) & MASK);
      b2_in = NW'((k * 53 + 700) & MASK);
      ab_ld1_n = c[0]; ab_ld2_n = c[1];
      ba_ld1_n = c[2]; ba_ld2_n = c[3];
      sel_n = c[4]; oe_a_n = c[5]; oe_b_n = c[6];
      step();
      check_all();
    end

    // R6: sel change has no effect before the next edge
    ba_ld1_n = 1'b0; ba_ld2_n = 1'b0; b1_in = 12'h111; b2_in = 12'h222; sel_n = 1'b0;
    step();
    ba_ld1_n = 1'b1; ba_ld2_n = 1'b1;
    chk(a_out, 12'h111, "R6 sel low picks 1B");
    sel_n = 1'b1;
    #1;
    chk(a_out, 12'h111, "R6 sel not yet sampled");
    step();
    chk(a_out, 12'h222, "R6 sel high picks 2B");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule